// File: doc/BRIEF.md
# Dual-Clock FIFO with Predictive Full and Empty Flags

This block moves a stream of data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Words are held in a small register array addressed directly by binary write and read counters. A write controller in the producer domain accepts a request only while the FIFO is not full. A read controller in the consumer domain accepts a request only while it is not empty. Each counter also keeps a registered gray-code copy, and that copy crosses into the opposite domain through a chain of at least two destination flops with no logic between them.

The full and empty indications are registered flags, and they are predicted one operation ahead. On an accepted write, the write controller compares the incremented pointer against the synchronized read pointer to decide whether the FIFO is now full. On an accepted read, the read controller compares the incremented pointer against the synchronized write pointer to decide whether the FIFO is now empty. Each flag is released only when the synchronized remote pointer shows that the other side has moved. Each domain has its own active-low asynchronous reset. Read data is registered.

Top module: `dual_clock_fifo`

## Requirements
- R1: With the reader idle and the read pointer fully synchronized, `wr_full` is 0 after the DEPTH-1-th write into an empty FIFO, and becomes 1 right after the wr_clk edge that accepts the DEPTH-th write. Capacity is exactly DEPTH words.
- R2: When an accepted read takes the last word the reader can see, `rd_empty` is 1 right after that same rd_clk edge.
- R3: Only accepted writes advance the write pointer and store data. Words leave in the order they were accepted, each exactly once.
- R4: `rd_data` takes the word at the read pointer on the rd_clk edge that accepts a read, and holds its value on every other edge.
- R5: A write request while `wr_full` is 1 is ignored. No word is stored, and the flag stays set.
- R6: A read request while `rd_empty` is 1 is ignored. `rd_data` and the read pointer are unchanged.
- R7: After reset, `wr_full` is 0, `rd_empty` is 1 and `rd_data` is 0. A newly written word is not readable at the first rd_clk edge after the write, because it must cross the synchronizer first.
- R8: Each pointer crosses domains in gray code: its registered gray value changes by at most one bit per source clock. At least two destination flops are used. Under free-running unrelated clocks no word is lost, duplicated or read early.
- R9: A set `wr_full` clears once the synchronized read pointer leaves the full distance. A set `rd_empty` clears once the synchronized write pointer differs from the read pointer, within a few destination clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_full | output | 1 | FIFO full; write requests are ignored while set |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | FIFO empty; read requests are ignored while set |

## Verification
An accepted write and an accepted read can happen at the same moment while one side sits at a flag boundary. For example, the reader can drain the last visible word just as a new word is crossing, or the writer can fill the last slot just as a read frees one. The bench provokes this with two concurrent phases under unrelated clocks. In one, the writer is throttled so the reader keeps hitting empty. In the other, the reader is throttled so the writer keeps hitting full. Each phase is judged by an in-order sequence scoreboard on every accepted read, and by confirming that blocked requests actually occurred at the boundary.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef logic [31:0] word_t;

  // Binary to reflected gray code.
  function automatic word_t gray_of(word_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary through a prefix XOR of all higher bits.
  function automatic word_t bin_of(word_t g);
    word_t b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  // Pointer that lies a full FIFO depth away (wrap bit inverted).
  function automatic word_t flip_top(word_t p, int unsigned w);
    return p ^ (word_t'(1) << (w - 1));
  endfunction

  // Distance a - b modulo 2**w.
  function automatic word_t ptr_gap(word_t a, word_t b, int unsigned w);
    return (a - b) & ((word_t'(1) << w) - 1);
  endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int  ADDR_W = 3,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PTR_W-1:0]  rsync_gray,
  output logic              fire,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  ptr_bin,
  output logic [PTR_W-1:0]  ptr_gray,
  output logic              full,
  output logic [PTR_W-1:0]  rsync_bin
);

  logic [PTR_W-1:0] ptr_step;
  logic [PTR_W-1:0] full_mark;

  assign rsync_bin = PTR_W'(bin_of(word_t'(rsync_gray)));
  assign full_mark = PTR_W'(flip_top(word_t'(rsync_bin), PTR_W));
  assign fire      = req & ~full;
  assign ptr_step  = ptr_bin + 1'b1;
  assign addr      = ptr_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
      full     <= 1'b0;
    end else if (fire) begin
      ptr_bin  <= ptr_step;
      ptr_gray <= PTR_W'(gray_of(word_t'(ptr_step)));
      full     <= (ptr_step == full_mark);
    end else begin
      full     <= full && (ptr_bin == full_mark);
    end
  end

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int  ADDR_W = 3,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PTR_W-1:0]  wsync_gray,
  output logic              fire,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  ptr_bin,
  output logic [PTR_W-1:0]  ptr_gray,
  output logic              empty,
  output logic [PTR_W-1:0]  wsync_bin
);

  logic [PTR_W-1:0] ptr_step;

  assign wsync_bin = PTR_W'(bin_of(word_t'(wsync_gray)));
  assign fire      = req & ~empty;
  assign ptr_step  = ptr_bin + 1'b1;
  assign addr      = ptr_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
      empty    <= 1'b1;
    end else if (fire) begin
      ptr_bin  <= ptr_step;
      ptr_gray <= PTR_W'(gray_of(word_t'(ptr_step)));
      empty    <= (ptr_step == wsync_bin);
    end else begin
      empty    <= empty && (ptr_bin == wsync_bin);
    end
  end

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)  rdata <= '0;
    else if (re)    rdata <= cells[raddr];
  end

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int PTR_W = ADDR_W + 1;

  // Named internal events, brought out for the bound checker.
  logic              wr_fire;
  logic              rd_fire;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [PTR_W-1:0]  wptr_bin;
  logic [PTR_W-1:0]  wptr_gray;
  logic [PTR_W-1:0]  rptr_bin;
  logic [PTR_W-1:0]  rptr_gray;
  logic [PTR_W-1:0]  wsync_gray;
  logic [PTR_W-1:0]  rsync_gray;
  logic [PTR_W-1:0]  wsync_bin;
  logic [PTR_W-1:0]  rsync_bin;

  dcf_wr_ctrl #(.ADDR_W(ADDR_W)) wr_ctrl_i (
    .clk        (wr_clk),
    .rst_n      (wr_rst_n),
    .req        (wr_req),
    .rsync_gray (rsync_gray),
    .fire       (wr_fire),
    .addr       (waddr),
    .ptr_bin    (wptr_bin),
    .ptr_gray   (wptr_gray),
    .full       (wr_full),
    .rsync_bin  (rsync_bin)
  );

  dcf_rd_ctrl #(.ADDR_W(ADDR_W)) rd_ctrl_i (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .req        (rd_req),
    .wsync_gray (wsync_gray),
    .fire       (rd_fire),
    .addr       (raddr),
    .ptr_bin    (rptr_bin),
    .ptr_gray   (rptr_gray),
    .empty      (rd_empty),
    .wsync_bin  (wsync_bin)
  );

  // Write pointer into the read domain.
  dcf_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) w2r_sync_i (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wptr_gray),
    .q     (wsync_gray)
  );

  // Read pointer into the write domain.
  dcf_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) r2w_sync_i (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rptr_gray),
    .q     (rsync_gray)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .wr_clk   (wr_clk),
    .we       (wr_fire),
    .waddr    (waddr),
    .wdata    (wr_data),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .re       (rd_fire),
    .raddr    (raddr),
    .rdata    (rd_data)
  );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int  DATA_W = 8,
  parameter int  ADDR_W = 3,
  localparam int PTR_W  = ADDR_W + 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_full,
  input logic              wr_fire,
  input logic [PTR_W-1:0]  wptr_bin,
  input logic [PTR_W-1:0]  wptr_gray,
  input logic [PTR_W-1:0]  rsync_bin,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_empty,
  input logic              rd_fire,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  rptr_bin,
  input logic [PTR_W-1:0]  rptr_gray,
  input logic [PTR_W-1:0]  wsync_bin
);

  logic [PTR_W-1:0] far_r;
  logic [PTR_W-1:0] wgap;
  logic [PTR_W-1:0] wnext;
  logic [PTR_W-1:0] rnext;

  assign far_r = {~rsync_bin[PTR_W-1], rsync_bin[PTR_W-2:0]};
  assign wgap  = wptr_bin - rsync_bin;
  assign wnext = wptr_bin + 1'b1;
  assign rnext = rptr_bin + 1'b1;

  // Write domain
  assert_full_predict_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_fire && (wnext == far_r)) |=> wr_full)
    else $error("full not predicted on filling write");

  assert_occupancy_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wgap <= PTR_W'(DEPTH))
    else $error("write pointer ran past capacity");

  assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wptr_bin))
    else $error("write pointer moved while full");

  assert_wgray_step_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1)
    else $error("write gray pointer changed more than one bit");

  assert_full_release_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && (wptr_bin != far_r)) |=> !wr_full)
    else $error("full held after read pointer moved");

  // Read domain
  assert_empty_predict_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_fire && (rnext == wsync_bin)) |=> rd_empty)
    else $error("empty not predicted on draining read");

  assert_rdata_hold_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_fire |=> $stable(rd_data))
    else $error("read data changed without a read");

  assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> ($stable(rptr_bin) && $stable(rd_data)))
    else $error("read consumed while empty");

  assert_rgray_step_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1)
    else $error("read gray pointer changed more than one bit");

  assert_empty_release_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && (wsync_bin != rptr_bin)) |=> !rd_empty)
    else $error("empty held after write pointer moved");

endmodule

bind dual_clock_fifo dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .wr_clk    (wr_clk),
  .wr_rst_n  (wr_rst_n),
  .wr_full   (wr_full),
  .wr_fire   (wr_fire),
  .wptr_bin  (wptr_bin),
  .wptr_gray (wptr_gray),
  .rsync_bin (rsync_bin),
  .rd_clk    (rd_clk),
  .rd_rst_n  (rd_rst_n),
  .rd_empty  (rd_empty),
  .rd_fire   (rd_fire),
  .rd_data   (rd_data),
  .rptr_bin  (rptr_bin),
  .rptr_gray (rptr_gray),
  .wsync_bin (wsync_bin)
);

// File: tb/dual_clock_fifo_tb_top.sv
module dual_clock_fifo_tb_top;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              wr_rst_n = 1'b0;
  logic              rd_rst_n = 1'b0;
  logic              wr_req = 1'b0;
  logic              rd_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wr_full;
  logic              rd_empty;

  int checks = 0;
  int errors = 0;

  always #5 wr_clk = ~wr_clk;   // 100 MHz
  always #8 rd_clk = ~rd_clk;   // unrelated slower reader

  dual_clock_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .wr_full  (wr_full),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_empty (rd_empty)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_write(input logic [DATA_W-1:0] d, output bit acc);
    @(negedge wr_clk);
    acc     = !wr_full;
    wr_req  = 1'b1;
    wr_data = d;
    @(posedge wr_clk);
    #1;
    wr_req  = 1'b0;
  endtask

  task automatic do_read(output bit acc, output logic [DATA_W-1:0] d);
    @(negedge rd_clk);
    acc    = !rd_empty;
    rd_req = 1'b1;
    @(posedge rd_clk);
    #1;
    rd_req = 1'b0;
    d      = rd_data;
  endtask

  task automatic wait_wr(int n);
    repeat (n) @(posedge wr_clk);
    #1;
  endtask

  task automatic wait_rd(int n);
    repeat (n) @(posedge rd_clk);
    #1;
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // ---------------------------------------------------------------
  task automatic t_reset_state();
    check_eq("R7", "wr_full after reset", int'(wr_full), 0);
    check_eq("R7", "rd_empty after reset", int'(rd_empty), 1);
    check_eq("R7", "rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic t_read_when_empty();
    bit acc;
    logic [DATA_W-1:0] d;
    do_read(acc, d);
    check_eq("R6", "read accepted while empty", int'(acc), 0);
    check_eq("R6", "rd_data after ignored read", int'(d), 0);
    check_eq("R6", "rd_empty after ignored read", int'(rd_empty), 1);
  endtask

  task automatic t_first_word();
    bit acc;
    bit seen;
    logic [DATA_W-1:0] d;
    do_write(8'hA5, acc);
    check_eq("R3", "first write accepted", int'(acc), 1);
    wait_rd(1);
    check_eq("R7", "word not visible at first rd edge", int'(rd_empty), 1);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (!rd_empty) seen = 1'b1;
      if (!seen) wait_rd(1);
    end
    check_eq("R9", "empty released after crossing", int'(seen), 1);
    do_read(acc, d);
    check_eq("R4", "first read data", int'(d), 'hA5);
    check_eq("R2", "empty predicted after last word", int'(rd_empty), 1);
    wait_rd(3);
    check_eq("R4", "rd_data held while idle", int'(rd_data), 'hA5);
  endtask

  task automatic t_fill_drain();
    bit acc;
    logic [DATA_W-1:0] d;
    wait_wr(6);
    for (int i = 0; i < DEPTH; i++) begin
      do_write(DATA_W'(8'h10 + i), acc);
      if (i == DEPTH - 2) check_eq("R1", "full after DEPTH-1 writes", int'(wr_full), 0);
    end
    check_eq("R1", "full after DEPTH writes", int'(wr_full), 1);
    do_write(8'hEE, acc);
    check_eq("R5", "write accepted while full", int'(acc), 0);
    check_eq("R5", "full held after ignored write", int'(wr_full), 1);
    wait_rd(6);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(acc, d);
      check_eq("R3", "drain order", int'(d), 'h10 + i);
    end
    check_eq("R2", "empty after drain", int'(rd_empty), 1);
    do_read(acc, d);
    check_eq("R6", "read accepted after drain", int'(acc), 0);
    check_eq("R6", "rd_data after ignored read", int'(d), 'h10 + DEPTH - 1);
  endtask

  task automatic t_full_release();
    bit acc;
    bit freed;
    logic [DATA_W-1:0] d;
    wait_wr(6);
    for (int i = 0; i < DEPTH; i++) do_write(DATA_W'(8'h30 + i), acc);
    check_eq("R1", "full after refill", int'(wr_full), 1);
    wait_rd(6);
    do_read(acc, d);
    check_eq("R3", "first word of refill", int'(d), 'h30);
    freed = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!wr_full) freed = 1'b1;
      if (!freed) wait_wr(1);
    end
    check_eq("R9", "full released after read", int'(freed), 1);
    do_write(8'h77, acc);
    check_eq("R1", "write into freed slot accepted", int'(acc), 1);
    check_eq("R1", "full again after freed slot used", int'(wr_full), 1);
    wait_rd(6);
    for (int i = 1; i <= DEPTH; i++) begin
      do_read(acc, d);
      check_eq("R3", "order after release", int'(d), (i == DEPTH) ? 'h77 : 'h30 + i);
    end
    check_eq("R2", "empty after second drain", int'(rd_empty), 1);
  endtask

  // Concurrent traffic; slow_wr throttles the writer, else the reader.
  task automatic t_concurrent(bit slow_wr, int n, int base);
    int blocked_w = 0;
    int blocked_r = 0;
    int bad = 0;
    fork
      begin : writer
        logic [15:0] s = 16'hACE1;
        int seq = 0;
        while (seq < n) begin
          s = lfsr_next(s);
          @(negedge wr_clk);
          if (!slow_wr || s[1:0] == 2'b00) begin
            wr_req  = 1'b1;
            wr_data = DATA_W'(base + seq);
            if (wr_full) blocked_w++;
            else         seq++;
          end
          @(posedge wr_clk);
          #1;
          wr_req = 1'b0;
        end
      end
      begin : reader
        logic [15:0] s = 16'h1D2B;
        int seq = 0;
        bit acc;
        while (seq < n) begin
          s = lfsr_next(s);
          @(negedge rd_clk);
          acc = 1'b0;
          if (slow_wr || s[1:0] == 2'b00) begin
            rd_req = 1'b1;
            acc    = !rd_empty;
            if (!acc) blocked_r++;
          end
          @(posedge rd_clk);
          #1;
          rd_req = 1'b0;
          if (acc) begin
            if (rd_data != DATA_W'(base + seq)) begin
              bad++;
              $display("FAIL R8 stream word %0d: actual %0d expected %0d",
                       seq, rd_data, DATA_W'(base + seq));
            end
            seq++;
          end
        end
      end
    join
    checks++;
    if (bad != 0) errors++;
    if (slow_wr) check_eq("R2", "reader blocked at empty boundary", int'(blocked_r > 0), 1);
    else         check_eq("R1", "writer blocked at full boundary", int'(blocked_w > 0), 1);
    wait_rd(6);
    check_eq("R3", "empty after stream drained", int'(rd_empty), 1);
  endtask

  initial begin
    repeat (5) @(posedge wr_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    wait_rd(2);
    t_reset_state();
    t_read_when_empty();
    t_first_word();
    t_fill_drain();
    t_full_release();
    t_concurrent(1'b1, 200, 0);
    t_concurrent(1'b0, 200, 100);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule